// File: doc/BRIEF.md
# Display Serial Command/Pixel Transmitter

This block is an SPI master that streams command and parameter bytes from an on-chip producer to a display controller. Each byte comes in on a valid/ready stream with a tag that says whether it is a command or data, and a marker that closes the transaction. Chip select goes low with the first byte and stays low until the byte carrying the marker has been shifted out. The serial clock follows SPI mode 0. Its half period is set in clock cycles by a configuration input.

Two framings are selectable. In the four-wire framing the tag drives a separate data/command pin and every byte is eight clocks long. In the three-wire framing that pin is held low and the tag travels as a ninth bit ahead of the byte. A command byte can also be marked as a register read. After its last bit the master releases the shared data line and gives a programmed number of dummy clocks, whose bits are discarded. It then captures one returned byte on eight rising edges and ends the transaction.

Top module: `disp_spi_tx`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `sda_oe` is 0 and `in_ready` is 1.
- R2: `sclk` is 0 whenever `cs_n` is 1. `sda_o` does not change while `sclk` is 1 and the line is driven. Bits go out MSB first. Every byte produces exactly one rising edge per frame bit.
- R3: With `cfg_three_wire` = 0 each byte is an 8-bit frame. `dc` equals the byte's tag (0 = command, 1 = data) at every rising edge of that frame, and `dc` changes only while `sclk` is 0.
- R4: With `cfg_three_wire` = 1 each byte is a 9-bit frame: first the tag (0 = command, 1 = data), then data bits 7 down to 0. `dc` stays 0.
- R5: Each high phase of `sclk` lasts exactly `cfg_div`+1 clock cycles, and so does the low phase before each rising edge of a frame.
- R6: `cs_n` falls once per transaction and stays low across all its bytes, including idle waits between them. It rises only after the byte with `in_last` = 1 (or a read command) has been sent.
- R7: A byte with `in_read` = 1 ends the write part. `sda_oe` drops after its last bit. The next `cfg_dummy` rising edges (0 counts as 1) ignore `sda_i`. The following 8 rising edges capture `sda_i` MSB first into `rd_data`, with a one-cycle `rd_valid` pulse while `cs_n` is still low.
- R8: `in_ready` is 1 only when no bit is in flight: in idle, or between bytes of an open transaction. It is never 1 while `sclk` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_three_wire | input | 1 | 1 = 9-bit framing with tag bit, 0 = separate dc pin |
| cfg_div | input | DIV_W | Half period of sclk minus one, in clk cycles |
| cfg_dummy | input | DUMMY_W | Dummy clocks before read data (1..8 in use) |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte accepted when both are high |
| in_data | input | BYTE_W | Byte to send |
| in_is_data | input | 1 | Tag: 1 = data/pixel, 0 = command |
| in_last | input | 1 | Closes the transaction after this byte |
| in_read | input | 1 | This command is followed by a one-byte readback |
| rd_valid | output | 1 | One-cycle pulse, readback complete |
| rd_data | output | BYTE_W | Captured readback byte |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| dc | output | 1 | Data/command pin for four-wire framing |
| sda_o | output | 1 | Serial data out |
| sda_oe | output | 1 | Output enable for the shared data line |
| sda_i | input | 1 | Serial data in from the shared line |

## Verification
The embedded assertions check on every cycle that the serial clock idles low under a released select, that data and `dc` hold still through each high phase, that the stream is never accepting mid-bit, that the line is driven only inside a transaction, and that the divider count stays in range. Frame contents, the tag position in either framing, the exact high-phase length, the count of select edges per transaction and the dummy-bit discard can only be shown by the bench. Its display model decodes the line on rising edges and returns known bytes behind junk dummy bits, across both framings, several dividers and every dummy count from 1 to 8.

// File: rtl/disp_spi_pkg.sv
// Package: shared types for the display serial transmitter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package disp_spi_pkg;

    // Sequencer states: idle, sclk low half, sclk high half,
    // waiting for next byte with select held, closing half period.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_WAIT,
        ST_GAP
    } seq_state_t;

    // What the current run of clocks is doing on the data line.
    typedef enum logic [1:0] {
        PH_WRITE,
        PH_DUMMY,
        PH_READ
    } phase_t;

endpackage

// File: rtl/disp_spi_clkdiv.sv
// Module: half-period tick generator for the serial clock.
// Emits one tick every div+1 cycles while run is high and restarts
// from zero whenever run drops. Assumes div is static during a transfer.
module disp_spi_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Count cycles within a half period; clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div);

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div)); // R5

endmodule

// File: rtl/disp_spi_ctrl.sv
// Module: frame sequencer for the display serial transmitter.
// Builds 8-bit or 9-bit frames, drives cs_n/sclk/dc/sda in SPI mode 0,
// and runs the dummy and capture phases of a register read.
// Assumes configuration inputs are stable while cs_n is low.
module disp_spi_ctrl
    import disp_spi_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int DUMMY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    output logic               run,
    input  logic               cfg_three_wire,
    input  logic [DUMMY_W-1:0] cfg_dummy,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BYTE_W-1:0]  in_data,
    input  logic               in_is_data,
    input  logic               in_last,
    input  logic               in_read,
    output logic               rd_valid,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               cs_n,
    output logic               sclk,
    output logic               dc,
    output logic               sda_o,
    output logic               sda_oe,
    input  logic               sda_i
);

    localparam int CNT_W = $clog2(BYTE_W + (1 << DUMMY_W) + 2);

    seq_state_t        state;
    phase_t            phase;
    logic [BYTE_W:0]   shreg;
    logic [CNT_W-1:0]  bits_left;
    logic              last_q;
    logic              rd_q;
    logic [BYTE_W-1:0] rd_sh;

    assign in_ready = (state == ST_IDLE) || (state == ST_WAIT);
    assign run      = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_GAP);
    assign sda_o    = shreg[BYTE_W];
    assign rd_data  = rd_sh;

    // Main sequencer: accept bytes, toggle sclk on ticks, walk phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_WRITE;
            shreg     <= '0;
            bits_left <= '0;
            last_q    <= 1'b0;
            rd_q      <= 1'b0;
            rd_sh     <= '0;
            rd_valid  <= 1'b0;
            cs_n      <= 1'b1;
            sclk      <= 1'b0;
            dc        <= 1'b0;
            sda_oe    <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE, ST_WAIT: begin
                    if (in_valid) begin
                        shreg     <= cfg_three_wire ? {in_is_data, in_data}
                                                    : {in_data, 1'b0};
                        bits_left <= cfg_three_wire ? CNT_W'(BYTE_W + 1)
                                                    : CNT_W'(BYTE_W);
                        dc        <= cfg_three_wire ? 1'b0 : in_is_data;
                        last_q    <= in_last || in_read;
                        rd_q      <= in_read;
                        phase     <= PH_WRITE;
                        cs_n      <= 1'b0;
                        sda_oe    <= 1'b1;
                        state     <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        state <= ST_HIGH;
                        if (phase == PH_READ) begin
                            rd_sh <= {rd_sh[BYTE_W-2:0], sda_i};
                        end
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (bits_left == CNT_W'(1)) begin
                            case (phase)
                                PH_WRITE: begin
                                    if (rd_q) begin
                                        phase     <= PH_DUMMY;
                                        bits_left <= (cfg_dummy == '0) ? CNT_W'(1)
                                                                       : CNT_W'(cfg_dummy);
                                        sda_oe    <= 1'b0;
                                        state     <= ST_LOW;
                                    end else if (last_q) begin
                                        state <= ST_GAP;
                                    end else begin
                                        state <= ST_WAIT;
                                    end
                                end
                                PH_DUMMY: begin
                                    phase     <= PH_READ;
                                    bits_left <= CNT_W'(BYTE_W);
                                    state     <= ST_LOW;
                                end
                                default: begin
                                    rd_valid <= 1'b1;
                                    state    <= ST_GAP;
                                end
                            endcase
                        end else begin
                            bits_left <= bits_left - 1'b1;
                            shreg     <= {shreg[BYTE_W-1:0], 1'b0};
                            state     <= ST_LOW;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        cs_n   <= 1'b1;
                        sda_oe <= 1'b0;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R2
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && sda_oe) |-> $stable(sda_o)); // R2
    AST_DC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(dc)); // R3
    AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !sclk); // R8
    AST_OE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> !cs_n); // R7
    AST_RD_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n); // R7

endmodule

// File: rtl/disp_spi_tx.sv
// Module: top of the display serial transmitter.
// Joins the half-period tick generator with the frame sequencer.
// Assumes a single clock domain and a synchronous active-low reset.
module disp_spi_tx #(
    parameter int BYTE_W  = 8,
    parameter int DIV_W   = 8,
    parameter int DUMMY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_three_wire,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [DUMMY_W-1:0] cfg_dummy,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BYTE_W-1:0]  in_data,
    input  logic               in_is_data,
    input  logic               in_last,
    input  logic               in_read,
    output logic               rd_valid,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               cs_n,
    output logic               sclk,
    output logic               dc,
    output logic               sda_o,
    output logic               sda_oe,
    input  logic               sda_i
);

    logic tick;
    logic run;

    disp_spi_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (cfg_div),
        .tick  (tick)
    );

    disp_spi_ctrl #(.BYTE_W(BYTE_W), .DUMMY_W(DUMMY_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .run            (run),
        .cfg_three_wire (cfg_three_wire),
        .cfg_dummy      (cfg_dummy),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_data        (in_data),
        .in_is_data     (in_is_data),
        .in_last        (in_last),
        .in_read        (in_read),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data),
        .cs_n           (cs_n),
        .sclk           (sclk),
        .dc             (dc),
        .sda_o          (sda_o),
        .sda_oe         (sda_oe),
        .sda_i          (sda_i)
    );

endmodule

// File: tb/tb_disp_spi_tx.sv
// Bench: drives byte streams in both framings and several dividers,
// decodes the serial line with a display model, and answers reads.
module tb_disp_spi_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_three_wire = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic [3:0] cfg_dummy = 4'd1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'd0;
    logic       in_is_data = 1'b0;
    logic       in_last = 1'b0;
    logic       in_read = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       cs_n, sclk, dc, sda_o, sda_oe;
    logic       sda_i;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    disp_spi_tx dut (
        .clk(clk), .rst_n(rst_n), .cfg_three_wire(cfg_three_wire),
        .cfg_div(cfg_div), .cfg_dummy(cfg_dummy), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_is_data(in_is_data),
        .in_last(in_last), .in_read(in_read), .rd_valid(rd_valid),
        .rd_data(rd_data), .cs_n(cs_n), .sclk(sclk), .dc(dc),
        .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    // Display model state
    logic [8:0] got_frame [0:15];
    logic       got_dc    [0:15];
    int         nfr = 0, nedges = 0, ncs_fall = 0, rx_bits = 0, rdc = 0;
    logic [8:0] rx_sh = '0;
    logic       dc_first = 1'b0;
    int         dummy_n = 1;
    logic [7:0] rd_val = 8'h00;
    int         hcnt = 0;
    int         hi_bad = 0;
    int         rd_seen = 0;
    logic [7:0] rd_got = 8'h00;

    always @(negedge cs_n) begin
        ncs_fall = ncs_fall + 1;
        rx_bits = 0;
        rdc = 0;
    end

    always @(posedge sclk) begin
        nedges = nedges + 1;
        if (!cs_n && sda_oe) begin
            rx_sh = {rx_sh[7:0], sda_o};
            if (rx_bits == 0) dc_first = dc;
            rx_bits = rx_bits + 1;
            if (rx_bits == (cfg_three_wire ? 9 : 8)) begin
                if (nfr < 16) begin
                    got_frame[nfr] = cfg_three_wire ? rx_sh : {1'b0, rx_sh[7:0]};
                    got_dc[nfr] = dc_first;
                end
                nfr = nfr + 1;
                rx_bits = 0;
            end
        end else if (!cs_n && !sda_oe) begin
            rdc = rdc + 1;
        end
    end

    // Slave drive: junk ones during dummy clocks, then rd_val MSB first
    always @* begin
        if (rdc < dummy_n) sda_i = 1'b1;
        else if (rdc < dummy_n + 8) sda_i = rd_val[7 - (rdc - dummy_n)];
        else sda_i = 1'b0;
    end

    // High-phase length monitor (R5)
    always @(negedge clk) begin
        if (sclk) hcnt = hcnt + 1;
        else begin
            if (hcnt != 0 && hcnt != int'(cfg_div) + 1) hi_bad = hi_bad + 1;
            hcnt = 0;
        end
        if (rd_valid) begin
            rd_seen = rd_seen + 1;
            rd_got = rd_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        nfr = 0; nedges = 0; ncs_fall = 0; hi_bad = 0; rd_seen = 0;
    endtask

    // Offer one byte and wait until it is taken
    task automatic send(input logic [7:0] d, input logic tag, input logic lst, input logic rd);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_is_data = tag; in_last = lst; in_read = rd;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_read = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(cs_n && in_ready)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    logic [7:0] tx_d   [0:7];
    logic       tx_tag [0:7];

    task automatic run_write(input int n, input int gap);
        int fsz;
        fsz = cfg_three_wire ? 9 : 8;
        clear_model();
        for (int i = 0; i < n; i++) begin
            send(tx_d[i], tx_tag[i], (i == n - 1), 1'b0);
            if (i == 0) chk(in_ready == 1'b0, "R8 busy after accept", in_ready, 0);
            repeat (gap) @(negedge clk);
        end
        wait_idle();
        chk(nfr == n, "R6 frame count", nfr, n);
        chk(ncs_fall == 1, "R6 single cs fall", ncs_fall, 1);
        chk(nedges == n * fsz, "R2 rising edges", nedges, n * fsz);
        chk(hi_bad == 0, "R5 high phase length", hi_bad, 0);
        for (int i = 0; i < n && i < 16; i++) begin
            if (cfg_three_wire) begin
                chk(got_frame[i] == {tx_tag[i], tx_d[i]}, "R4 nine-bit frame",
                    got_frame[i], {tx_tag[i], tx_d[i]});
                chk(got_dc[i] == 1'b0, "R4 dc held low", got_dc[i], 0);
            end else begin
                chk(got_frame[i][7:0] == tx_d[i], "R3 byte MSB first",
                    got_frame[i][7:0], tx_d[i]);
                chk(got_dc[i] == tx_tag[i], "R3 dc tag", got_dc[i], tx_tag[i]);
            end
        end
    endtask

    task automatic run_read(input logic [7:0] cmd, input int dmy, input logic [7:0] val);
        int fsz;
        fsz = cfg_three_wire ? 9 : 8;
        clear_model();
        cfg_dummy = 4'(dmy);
        dummy_n = dmy;
        rd_val = val;
        send(cmd, 1'b0, 1'b0, 1'b1);
        wait_idle();
        chk(rd_seen == 1, "R7 one rd_valid pulse", rd_seen, 1);
        chk(rd_got == val, "R7 read byte after dummies", rd_got, val);
        chk(nfr == 1, "R7 command frame", nfr, 1);
        chk(got_frame[0][7:0] == cmd, "R7 command byte", got_frame[0][7:0], cmd);
        chk(nedges == fsz + dmy + 8, "R7 total clocks", nedges, fsz + dmy + 8);
        chk(ncs_fall == 1, "R6 read single cs", ncs_fall, 1);
        chk(hi_bad == 0, "R5 high phase in read", hi_bad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk reset", sclk, 0);
        chk(sda_oe == 1'b0, "R1 oe reset", sda_oe, 0);
        chk(in_ready == 1'b1, "R1 ready reset", in_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int tw = 0; tw < 2; tw++) begin
            for (int dv = 0; dv < 4; dv++) begin
                cfg_three_wire = tw[0];
                cfg_div = (dv == 3) ? 8'd4 : 8'(dv);
                // single command
                tx_d[0] = 8'(8'h2A + tw * 3 + dv); tx_tag[0] = 1'b0;
                run_write(1, 0);
                // command plus RGB565 pixel
                tx_d[0] = 8'h2C; tx_tag[0] = 1'b0;
                tx_d[1] = 8'hF8; tx_tag[1] = 1'b1;
                tx_d[2] = 8'h1F; tx_tag[2] = 1'b1;
                run_write(3, 0);
                // arithmetic pattern with idle gaps between bytes
                for (int i = 0; i < 5; i++) begin
                    tx_d[i] = 8'((i * 37 + tw * 11 + dv * 5 + 1) & 255);
                    tx_tag[i] = i[0];
                end
                run_write(5, 3 + dv);
            end
        end

        for (int tw = 0; tw < 2; tw++) begin
            for (int dv = 0; dv < 3; dv += 2) begin
                cfg_three_wire = tw[0];
                cfg_div = 8'(dv);
                for (int d = 1; d <= 8; d++) begin
                    run_read(8'h04, d, 8'((d * 29 + tw * 7 + dv) & 255));
                    run_read(8'h0A, d, 8'h00);
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule